// File: doc/BRIEF.md
# Printer Port Register Block

This block is the host-facing register set of a classic byte-wide printer port. A processor reaches it through a simple register bus with one-cycle read and write strobes. Only the three low address bits select a register, so the block fills an eight-byte window and aliases across any wider address. It holds an output data latch, an input data latch, a status byte and a control byte.

The printer handshake is modelled in a simplified form that is driven by register accesses and not by pin timing. A control write that raises the strobe sends the output latch to a downstream character sink as a one-cycle valid pulse. Repeated status reads then walk the busy and acknowledge bits back to their idle state. If interrupts are enabled, a control write that drops the strobe while the device is selected raises an interrupt request. The next status read clears that request.

The input latch is loaded from an external byte port on a load strobe. The direction bit of the control byte chooses which latch a data read returns.

Top module: `ppr_port`

## Requirements
- R1: After reset: data reads return 0xFF, status reads 0xD9 (bits 7, 6, 4, 3, 0 set), control reads 0xCC, the irq output is 0, sink_valid is 0 and bus_rdata is 0x00.
- R2: Only address bits 2:0 are decoded, with offset 0 = data, 1 = status and 2 = control. Reads at offsets 3 to 7 return 0xFF. Higher address bits are ignored.
- R3: A control write stores the written byte with bits 7 and 6 forced to 1, and a control read returns the stored byte.
- R4: A control write with bit 2 (init) at 0 loads status with 0xD8, which also clears the timeout flag in bit 0.
- R5: A control write with bit 2 = 1, bit 3 (select) = 1 and bit 0 (strobe) = 1 clears status bit 7 (busy). If the stored strobe was 0 before the write, the block also drives sink_valid high for exactly one cycle, with the output latch on sink_data.
- R6: A control write with bit 2 = 1, bit 3 = 1 and bit 0 = 0 sets the interrupt-pending flag if bit 4 (interrupt enable) of the previously stored control byte is 1. A write with bit 3 = 0 never sets the flag. irq follows the flag.
- R7: A status read returns the current status and clears the interrupt-pending flag. If status bit 7 was 0 and the stored strobe is 0, the read then clears bit 6 when bit 6 was 1, and otherwise sets both bit 6 and bit 7.
- R8: A data read returns the input latch when control bit 5 is 1, and the output latch when it is 0. A data write loads the output latch.
- R9: ext_load loads ext_din into the input latch.
- R10: Read data appears on bus_rdata one cycle after the read strobe and holds until the next read. A read in the same cycle as a write is dropped. Writes to status and to offsets 3 to 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register address; low three bits decoded |
| bus_wr | input | 1 | One-cycle write strobe |
| bus_rd | input | 1 | One-cycle read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| ext_din | input | 8 | Byte for the input latch |
| ext_load | input | 1 | Loads ext_din into the input latch |
| sink_data | output | 8 | Byte sent to the character sink |
| sink_valid | output | 1 | One-cycle pulse marking a sent byte |
| irq | output | 1 | Interrupt request (pending flag) |

## Verification
The bench builds the block with ADDR_W = 5 instead of the default 3. This places nonzero bits above the decoded field, so accesses such as 0x1A and 0x0B show that the upper bits alias away and that undecoded offsets read 0xFF. With that width, the control byte's direction, enable and strobe bits can be driven through the full handshake walk, the repeated-strobe case and the interrupt enable-then-drop order, while a behavioural model tracks every cycle.

// File: rtl/ppr_pkg.sv
package ppr_pkg;
  localparam int BYTE_W = 8;
  localparam int OFS_W  = 3;

  // decoded register offsets (behavioural: software addresses them)
  localparam int OFS_DATA = 0;
  localparam int OFS_STAT = 1;
  localparam int OFS_CTRL = 2;
  localparam int N_REGS   = 3;

  // status bit positions
  localparam int ST_BUSY_N = 7;
  localparam int ST_ACK    = 6;
  localparam int ST_PAPER  = 5;
  localparam int ST_ONLINE = 4;
  localparam int ST_ERR_N  = 3;
  localparam int ST_TMO    = 0;

  // control bit positions
  localparam int CT_DIR   = 5;
  localparam int CT_IEN   = 4;
  localparam int CT_SEL   = 3;
  localparam int CT_INIT  = 2;
  localparam int CT_ALF   = 1;
  localparam int CT_STB   = 0;

  localparam logic [BYTE_W-1:0] CTRL_FORCE = 8'hC0;
  localparam logic [BYTE_W-1:0] CTRL_RST   = 8'hCC;
  localparam logic [BYTE_W-1:0] STAT_IDLE  = 8'hD8;
  localparam logic [BYTE_W-1:0] STAT_RST   = 8'hD9;
  localparam logic [BYTE_W-1:0] DATA_RST   = 8'hFF;
  localparam logic [BYTE_W-1:0] OPEN_BUS   = 8'hFF;

  typedef enum logic [1:0] {
    SEL_DATA = 2'd0,
    SEL_STAT = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/ppr_decode.sv
module ppr_decode
  import ppr_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  output reg_sel_e          sel,
  output logic              wr_data,
  output logic              wr_ctrl,
  output logic              rd_stat,
  output logic              rd_go
);
  localparam logic [ADDR_W-1:0] OFS_MASK = ADDR_W'((1 << OFS_W) - 1);

  logic [N_REGS-1:0] hit;

  genvar g;
  generate
    for (g = 0; g < N_REGS; g++) begin : g_hit
      assign hit[g] = ((addr & OFS_MASK) == ADDR_W'(g));
    end
  endgenerate

  always_comb begin
    sel = SEL_NONE;
    if (hit[OFS_DATA]) sel = SEL_DATA;
    if (hit[OFS_STAT]) sel = SEL_STAT;
    if (hit[OFS_CTRL]) sel = SEL_CTRL;
  end

  // a write in the same cycle wins; the read is dropped
  assign rd_go   = rd & ~wr;
  assign wr_data = wr & hit[OFS_DATA];
  assign wr_ctrl = wr & hit[OFS_CTRL];
  assign rd_stat = rd_go & hit[OFS_STAT];
endmodule

// File: rtl/ppr_latches.sv
module ppr_latches
  import ppr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_data,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              ext_load,
  input  logic [BYTE_W-1:0] ext_din,
  output logic [BYTE_W-1:0] out_q,
  output logic [BYTE_W-1:0] in_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_q <= DATA_RST;
      in_q  <= DATA_RST;
    end else begin
      if (wr_data)  out_q <= wdata;
      if (ext_load) in_q  <= ext_din;
    end
  end

  // R9
  in_load_chk: assert property (@(posedge clk) disable iff (rst)
    ext_load |=> (in_q == $past(ext_din)));
endmodule

// File: rtl/ppr_handshake.sv
module ppr_handshake
  import ppr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_ctrl,
  input  logic              rd_stat,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [BYTE_W-1:0] out_byte,
  output logic [BYTE_W-1:0] ctrl_q,
  output logic [BYTE_W-1:0] stat_q,
  output logic              pend_q,
  output logic              emit_q,
  output logic [BYTE_W-1:0] emit_byte_q
);
  logic [BYTE_W-1:0] ctrl_nx;
  assign ctrl_nx = wdata | CTRL_FORCE;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q      <= CTRL_RST;
      stat_q      <= STAT_RST;
      pend_q      <= 1'b0;
      emit_q      <= 1'b0;
      emit_byte_q <= '0;
    end else begin
      emit_q <= 1'b0;
      if (wr_ctrl) begin
        ctrl_q <= ctrl_nx;
        if (!ctrl_nx[CT_INIT]) begin
          stat_q <= STAT_IDLE;
        end else if (ctrl_nx[CT_SEL]) begin
          if (ctrl_nx[CT_STB]) begin
            stat_q[ST_BUSY_N] <= 1'b0;
            if (!ctrl_q[CT_STB]) begin
              emit_q      <= 1'b1;
              emit_byte_q <= out_byte;
            end
          end else if (ctrl_q[CT_IEN]) begin
            pend_q <= 1'b1;
          end
        end
      end else if (rd_stat) begin
        pend_q <= 1'b0;
        if (!stat_q[ST_BUSY_N] && !ctrl_q[CT_STB]) begin
          if (stat_q[ST_ACK]) begin
            stat_q[ST_ACK] <= 1'b0;
          end else begin
            stat_q[ST_ACK]    <= 1'b1;
            stat_q[ST_BUSY_N] <= 1'b1;
          end
        end
      end
    end
  end

  // R3
  ctl_hi_chk: assert property (@(posedge clk) disable iff (rst)
    ctrl_q[7:6] == 2'b11);
  // R4
  init_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_ctrl && !wdata[CT_INIT]) |=> (stat_q == STAT_IDLE));
  // R5
  emit_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    emit_q |=> !emit_q);
  // R5
  emit_cause_chk: assert property (@(posedge clk) disable iff (rst)
    emit_q |-> ($past(wr_ctrl) && !stat_q[ST_BUSY_N] && ctrl_q[CT_STB]));
  // R7
  rd_clear_chk: assert property (@(posedge clk) disable iff (rst)
    rd_stat |=> !pend_q);
  // R6
  pend_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pend_q) |-> ($past(wr_ctrl) && $past(ctrl_q[CT_IEN])));
endmodule

// File: rtl/ppr_port.sv
module ppr_port
  import ppr_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic [7:0]        ext_din,
  input  logic              ext_load,
  output logic [7:0]        sink_data,
  output logic              sink_valid,
  output logic              irq
);
  reg_sel_e          sel;
  logic              wr_data, wr_ctrl, rd_stat, rd_go;
  logic [BYTE_W-1:0] out_q, in_q, ctrl_q, stat_q;
  logic              pend_q;
  logic [BYTE_W-1:0] rd_mux;
  logic [BYTE_W-1:0] rdata_q;

  ppr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr    (bus_addr),
    .wr      (bus_wr),
    .rd      (bus_rd),
    .sel     (sel),
    .wr_data (wr_data),
    .wr_ctrl (wr_ctrl),
    .rd_stat (rd_stat),
    .rd_go   (rd_go)
  );

  ppr_latches u_lat (
    .clk      (clk),
    .rst      (rst),
    .wr_data  (wr_data),
    .wdata    (bus_wdata),
    .ext_load (ext_load),
    .ext_din  (ext_din),
    .out_q    (out_q),
    .in_q     (in_q)
  );

  ppr_handshake u_hs (
    .clk         (clk),
    .rst         (rst),
    .wr_ctrl     (wr_ctrl),
    .rd_stat     (rd_stat),
    .wdata       (bus_wdata),
    .out_byte    (out_q),
    .ctrl_q      (ctrl_q),
    .stat_q      (stat_q),
    .pend_q      (pend_q),
    .emit_q      (sink_valid),
    .emit_byte_q (sink_data)
  );

  always_comb begin
    unique case (sel)
      SEL_DATA: rd_mux = ctrl_q[CT_DIR] ? in_q : out_q;
      SEL_STAT: rd_mux = stat_q;
      SEL_CTRL: rd_mux = ctrl_q;
      default:  rd_mux = OPEN_BUS;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata_q <= '0;
    else if (rd_go) rdata_q <= rd_mux;
  end

  assign bus_rdata = rdata_q;
  assign irq       = pend_q;

  // R10
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rd_go) |-> $stable(rdata_q));
  // R10
  both_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_rd) |=> $stable(bus_rdata));
endmodule

// File: tb/tb_ppr_port.sv
module tb_ppr_port;
  localparam int AW = 5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_wr = 1'b0;
  logic          bus_rd = 1'b0;
  logic [7:0]    bus_wdata = '0;
  logic [7:0]    bus_rdata;
  logic [7:0]    ext_din = '0;
  logic          ext_load = 1'b0;
  logic [7:0]    sink_data;
  logic          sink_valid;
  logic          irq;

  always #2.5 clk = ~clk;

  ppr_port #(.ADDR_W(AW)) dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ext_din(ext_din), .ext_load(ext_load), .sink_data(sink_data),
    .sink_valid(sink_valid), .irq(irq)
  );

  int n_cmp = 0;
  int n_bad = 0;

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // behavioural reference model
  int m_dw, m_dr, m_st, m_ct, m_pend, m_rd, m_sv, m_sd, nv, ofs;
  bit started = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_dw = 'hFF; m_dr = 'hFF; m_st = 'hD9; m_ct = 'hCC;
      m_pend = 0; m_rd = 0; m_sv = 0; m_sd = 0;
      started = 1;
    end else begin
      m_sv = 0;
      ofs = int'(bus_addr) % 8;
      if (bus_wr) begin
        if (ofs == 0) m_dw = int'(bus_wdata);
        if (ofs == 2) begin
          nv = int'(bus_wdata) | 'hC0;
          if ((nv & 4) == 0) m_st = 'hD8;
          else if ((nv & 8) != 0) begin
            if ((nv & 1) != 0) begin
              m_st = m_st & 'h7F;
              if ((m_ct & 1) == 0) begin m_sv = 1; m_sd = m_dw; end
            end else if ((m_ct & 'h10) != 0) m_pend = 1;
          end
          m_ct = nv;
        end
      end else if (bus_rd) begin
        case (ofs)
          0: m_rd = ((m_ct & 'h20) != 0) ? m_dr : m_dw;
          1: begin
            m_rd = m_st;
            m_pend = 0;
            if ((m_st & 'h80) == 0 && (m_ct & 1) == 0) begin
              if ((m_st & 'h40) != 0) m_st = m_st & 'hBF;
              else m_st = m_st | 'hC0;
            end
          end
          2: m_rd = m_ct;
          default: m_rd = 'hFF;
        endcase
      end
      if (ext_load) m_dr = int'(ext_din);
    end
  end

  always @(negedge clk) begin
    if (started && !rst) begin
      chk("R10 model rdata", int'(bus_rdata), m_rd);
      chk("R5 model sink_valid", int'(sink_valid), m_sv);
      if (m_sv != 0) chk("R5 model sink_data", int'(sink_data), m_sd);
      chk("R6 model irq", int'(irq), m_pend);
    end
  end

  task automatic wr_reg(input int a, input int d);
    @(negedge clk);
    bus_addr = AW'(a); bus_wdata = 8'(d); bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_reg(input int a, output int v);
    @(negedge clk);
    bus_addr = AW'(a); bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    v = int'(bus_rdata);
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset values
    chk("R1 irq", int'(irq), 0);
    chk("R1 sink_valid", int'(sink_valid), 0);
    chk("R1 rdata", int'(bus_rdata), 0);
    rd_reg(0, v); chk("R1 data", v, 'hFF);
    rd_reg(1, v); chk("R1 status", v, 'hD9);
    rd_reg(2, v); chk("R1 control", v, 'hCC);
    // R2 decode and aliasing
    rd_reg('h0B, v); chk("R2 offset3", v, 'hFF);
    rd_reg('h1F, v); chk("R2 offset7", v, 'hFF);
    rd_reg('h1A, v); chk("R2 alias ctrl", v, 'hCC);
    // R10 writes to status / undecoded have no effect
    wr_reg(1, 'h00);
    wr_reg(5, 'h00);
    rd_reg(1, v); chk("R10 status write ignored", v, 'hD9);
    rd_reg(2, v); chk("R10 undecoded write ignored", v, 'hCC);
    // R8 / R9 data path
    wr_reg(0, 'h5A);
    rd_reg(0, v); chk("R8 out latch", v, 'h5A);
    @(negedge clk); ext_din = 8'h3C; ext_load = 1'b1;
    @(negedge clk); ext_load = 1'b0;
    rd_reg(0, v); chk("R8 dir0 ignores input", v, 'h5A);
    wr_reg(2, 'h2C);
    rd_reg(8, v); chk("R9 input latch via dir1", v, 'h3C);
    rd_reg(2, v); chk("R3 forced high bits", v, 'hEC);
    // R5 strobe emission
    wr_reg(2, 'h0C);
    wr_reg(2, 'h0D);
    chk("R5 sink_valid pulse", int'(sink_valid), 1);
    chk("R5 sink_data", int'(sink_data), 'h5A);
    @(negedge clk);
    chk("R5 pulse one cycle", int'(sink_valid), 0);
    wr_reg(2, 'h0C);
    // R7 handshake walk (strobe stored 0, busy cleared earlier)
    rd_reg(1, v); chk("R5 busy cleared", v, 'h59);
    rd_reg(1, v); chk("R7 ack cleared", v, 'h19);
    rd_reg(1, v); chk("R7 ack+busy set", v, 'hD9);
    rd_reg(1, v); chk("R7 idle stays", v, 'hD9);
    // R5 repeated strobe: no new pulse
    wr_reg(2, 'h0D);
    wr_reg(2, 'h0D);
    chk("R5 no pulse when strobe already 1", int'(sink_valid), 0);
    rd_reg(1, v); chk("R7 no walk while strobe 1", v, 'h59);
    rd_reg(1, v); chk("R7 still no walk", v, 'h59);
    // R4 init low
    wr_reg(2, 'h08);
    rd_reg(1, v); chk("R4 idle status", v, 'hD8);
    // R6 interrupt
    wr_reg(2, 'h1C);
    chk("R6 no irq without prior enable", int'(irq), 0);
    wr_reg(2, 'h1C);
    chk("R6 irq raised", int'(irq), 1);
    wr_reg(0, 'hA5);
    chk("R6 irq held", int'(irq), 1);
    rd_reg(1, v); chk("R7 status on clear", v, 'hD8);
    chk("R7 irq cleared by status read", int'(irq), 0);
    wr_reg(2, 'h14);
    chk("R6 select low no irq", int'(irq), 0);
    // R10 read with write: read dropped, rdata holds
    rd_reg(2, v); chk("R3 readback", v, 'hD4);
    @(negedge clk);
    bus_addr = AW'(0); bus_wdata = 8'h77; bus_wr = 1'b1; bus_rd = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
    chk("R10 read dropped on write", int'(bus_rdata), 'hD4);
    repeat (3) @(negedge clk);
    chk("R10 rdata holds", int'(bus_rdata), 'hD4);
    rd_reg(0, v); chk("R8 write took effect", v, 'h77);
    repeat (4) @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule